// File: doc/BRIEF.md
# Station Address Table Command Engine

This block keeps a small table of station addresses for a two-port Ethernet switch and changes it on command from software. Software first loads a 48-bit station address into two staging registers and then writes a command word. The word names a destination port, a VLAN ID and an age value, and it has a start bit. The engine then walks the whole table one entry per cycle, looking for an entry with the same address and VID and for the lowest free slot. In one final cycle it installs, refreshes or removes the entry and raises a done flag. Software polls that flag.

No separate delete command exists. A command with an age of zero removes the matching entry. A command with a nonzero age installs the entry, or updates it in place if it is already present. If a new address arrives while every slot is in use, a sticky overflow flag is set.

The frame path queries the table through a valid/ready lookup stream that carries an address and a VID. The answer is a hit flag and a port, and it comes back on a response stream. A query is accepted only in a cycle where `lk_valid` and `lk_ready` are both high. The response appears on the next cycle. `lk_ready` is low while a response is waiting and `rsp_ready` is low, so the frame path can stall the block by holding `rsp_ready` low. While stalled, the pending response keeps its values.

Top module: `mtbl_top`

## Requirements
- R1: Address layout. Select 0 is the low staging register: octet 0 is in bits 7:0, octet 1 is in bits 15:8, and bits 31:16 are ignored. Select 1 is the high staging register: octets 2, 3, 4 and 5 are in bits 7:0, 15:8, 23:16 and 31:24. The lookup address uses the same order, with octet 0 in `lk_mac[7:0]` and octet 5 in `lk_mac[47:40]`.
- R2: Command word layout at select 2: bit 0 is start, bit 1 is the port (0 = CPU port, 1 = LAN port 0), bits 4:2 are the age and bits 16:5 are the VID. Writing it with start set while idle begins an operation. On the next cycle busy is high and done is low.
- R3: Every operation ends within DEPTH+2 cycles of the command write. Done then reads 1 and busy reads 0, and the two are never high together.
- R4: A command with nonzero age whose address and VID match no valid entry installs them in a free slot. A later lookup hits and returns the commanded port.
- R5: A command with nonzero age whose address and VID match a valid entry overwrites that entry in place with the new port and age. No extra slot is used, so this succeeds even when the table is full.
- R6: A command with age zero invalidates the matching entry, and later lookups miss. If nothing matches, no entry changes and the overflow flag does not change.
- R7: A command with nonzero age for a new address when all DEPTH slots are valid leaves the table unchanged and sets `tbl_overflow`. The flag stays set until reset.
- R8: Command writes while busy are ignored. A command write with start clear has no effect and leaves done as it was.
- R9: A lookup response follows its accepted query by one cycle. Hit is 1 only if a valid entry with nonzero age matches both the address and the VID. On a hit the port is that entry's port, and on a miss the port is 0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its values and `lk_ready` is low.
- R11: After reset, busy, done, overflow and `rsp_valid` are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 low staging, 1 high staging, 2 command |
| cfg_wdata | input | 32 | Register write data |
| cmd_busy | output | 1 | Operation in progress |
| cmd_done | output | 1 | Last operation finished |
| tbl_overflow | output | 1 | Sticky: an install found the table full |
| lk_valid | input | 1 | Lookup query valid |
| lk_ready | output | 1 | Lookup query can be accepted |
| lk_mac | input | 48 | Lookup address, octet 0 in bits 7:0 |
| lk_vid | input | 12 | Lookup VLAN ID |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Lookup found an entry |
| rsp_port | output | 1 | Port of the found entry (0 CPU, 1 LAN 0) |

## Verification
The properties assume that `cfg_sel` never takes the unused value 3. They also assume that a lookup query keeps its address and VID steady until `lk_ready` accepts it. The stimulus writes registers only through a task that drives one select at a time, and it holds `lk_valid` with fixed data until the acceptance edge. Software is expected to install any address at most once per VID. The stimulus keeps to that, so a lookup never sees two hits, and later changes to that address go through refresh or removal commands.

// File: rtl/mtbl_pkg.sv
package mtbl_pkg;
  localparam int MAC_W = 48;
  localparam int VID_W = 12;
  localparam int AGE_W = 3;

  // command word fields
  localparam int CMD_START_BIT = 0;
  localparam int CMD_PORT_BIT  = 1;
  localparam int CMD_AGE_LSB   = 2;
  localparam int CMD_VID_LSB   = CMD_AGE_LSB + AGE_W;
  localparam int CMD_W         = CMD_VID_LSB + VID_W;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_CMD     = 2'd2;

  typedef struct packed {
    logic             valid;
    logic [MAC_W-1:0] mac;
    logic [VID_W-1:0] vid;
    logic             port;
    logic [AGE_W-1:0] age;
  } entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} eng_state_e;
endpackage

// File: rtl/mtbl_staging.sv
module mtbl_staging
  import mtbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [MAC_W-1:0] stage_mac
);
  logic [15:0] lo_q;
  logic [31:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_ADDR_LO) lo_q <= cfg_wdata[15:0];
      if (cfg_sel == SEL_ADDR_HI) hi_q <= cfg_wdata;
    end
  end

  // octet 0 lands in the least significant byte
  assign stage_mac = {hi_q, lo_q};
endmodule

// File: rtl/mtbl_store.sv
module mtbl_store
  import mtbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [MAC_W-1:0] rd_mac,
  output logic [VID_W-1:0] rd_vid,
  input  logic [MAC_W-1:0] lk_mac,
  input  logic [VID_W-1:0] lk_vid,
  output logic             lk_hit,
  output logic             lk_port
);
  entry_t tbl_q [DEPTH];
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] port_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_entry;
    end
  end

  assign rd_valid = tbl_q[rd_idx].valid;
  assign rd_mac   = tbl_q[rd_idx].mac;
  assign rd_vid   = tbl_q[rd_idx].vid;

  // parallel compare for the frame-path lookup
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g]  = tbl_q[g].valid && (tbl_q[g].age != '0) &&
                         (tbl_q[g].mac == lk_mac) && (tbl_q[g].vid == lk_vid);
    assign port_vec[g] = tbl_q[g].port;
  end

  assign lk_hit  = |hit_vec;
  assign lk_port = |(hit_vec & port_vec);
endmodule

// File: rtl/mtbl_engine.sv
module mtbl_engine
  import mtbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic [MAC_W-1:0] stage_mac,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [MAC_W-1:0] rd_mac,
  input  logic [VID_W-1:0] rd_vid,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output entry_t           wr_entry,
  output logic             busy,
  output logic             done,
  output logic             overflow
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  eng_state_e       state_q;
  logic [MAC_W-1:0] op_mac_q;
  logic [VID_W-1:0] op_vid_q;
  logic             op_port_q;
  logic [AGE_W-1:0] op_age_q;
  logic [IDX_W-1:0] scan_idx_q, hit_idx_q, free_idx_q;
  logic             hit_found_q, free_found_q;
  logic             done_q, ovf_q;

  logic cmd_go, scan_match, scan_free;

  assign cmd_go     = cfg_we && (cfg_sel == SEL_CMD) && cmd_word[CMD_START_BIT] &&
                      (state_q == ST_IDLE);
  assign rd_idx     = scan_idx_q;
  assign scan_match = rd_valid && (rd_mac == op_mac_q) && (rd_vid == op_vid_q);
  assign scan_free  = !rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      op_mac_q     <= '0;
      op_vid_q     <= '0;
      op_port_q    <= 1'b0;
      op_age_q     <= '0;
      scan_idx_q   <= '0;
      hit_idx_q    <= '0;
      free_idx_q   <= '0;
      hit_found_q  <= 1'b0;
      free_found_q <= 1'b0;
      done_q       <= 1'b0;
      ovf_q        <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_go) begin
            op_mac_q     <= stage_mac;
            op_vid_q     <= cmd_word[CMD_VID_LSB +: VID_W];
            op_port_q    <= cmd_word[CMD_PORT_BIT];
            op_age_q     <= cmd_word[CMD_AGE_LSB +: AGE_W];
            scan_idx_q   <= '0;
            hit_found_q  <= 1'b0;
            free_found_q <= 1'b0;
            done_q       <= 1'b0;
            state_q      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_match && !hit_found_q) begin
            hit_found_q <= 1'b1;
            hit_idx_q   <= scan_idx_q;
          end
          if (scan_free && !free_found_q) begin
            free_found_q <= 1'b1;
            free_idx_q   <= scan_idx_q;
          end
          if (scan_idx_q == LAST_IDX) state_q <= ST_COMMIT;
          else                        scan_idx_q <= scan_idx_q + 1'b1;
        end
        ST_COMMIT: begin
          if ((op_age_q != '0) && !hit_found_q && !free_found_q) ovf_q <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en          = 1'b0;
    wr_idx         = hit_idx_q;
    wr_entry.valid = 1'b1;
    wr_entry.mac   = op_mac_q;
    wr_entry.vid   = op_vid_q;
    wr_entry.port  = op_port_q;
    wr_entry.age   = op_age_q;
    if (state_q == ST_COMMIT) begin
      if (op_age_q == '0) begin
        if (hit_found_q) begin
          wr_en    = 1'b1;
          wr_entry = '0;
        end
      end else if (hit_found_q) begin
        wr_en = 1'b1;
      end else if (free_found_q) begin
        wr_en  = 1'b1;
        wr_idx = free_idx_q;
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/mtbl_top.sv
module mtbl_top
  import mtbl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        cmd_busy,
  output logic        cmd_done,
  output logic        tbl_overflow,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [47:0] lk_mac,
  input  logic [11:0] lk_vid,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_hit,
  output logic        rsp_port
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [MAC_W-1:0] stage_mac;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             rd_valid, wr_en;
  logic [MAC_W-1:0] rd_mac;
  logic [VID_W-1:0] rd_vid;
  entry_t           wr_entry;
  logic             cmp_hit, cmp_port;
  logic             rsp_valid_q, rsp_hit_q, rsp_port_q;

  mtbl_staging u_stage (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stage_mac(stage_mac)
  );

  mtbl_engine #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cmd_word(cfg_wdata[CMD_W-1:0]), .stage_mac(stage_mac),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_mac(rd_mac), .rd_vid(rd_vid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .busy(cmd_busy), .done(cmd_done), .overflow(tbl_overflow)
  );

  mtbl_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_mac(rd_mac), .rd_vid(rd_vid),
    .lk_mac(lk_mac), .lk_vid(lk_vid), .lk_hit(cmp_hit), .lk_port(cmp_port)
  );

  // single response slot; a new query may enter as the old answer leaves
  assign lk_ready = !rsp_valid_q || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_port_q  <= 1'b0;
    end else if (lk_valid && lk_ready) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= cmp_hit;
      rsp_port_q  <= cmp_port;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_port  = rsp_port_q;
endmodule

// File: rtl/mtbl_checker.sv
module mtbl_checker #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        cmd_busy,
  input logic        cmd_done,
  input logic        tbl_overflow,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic        rsp_port
);
  logic [31:0] busy_cnt;
  logic        start_wr;

  assign start_wr = cfg_we && (cfg_sel == 2'd2) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (cmd_busy) busy_cnt <= busy_cnt + 1;
    else               busy_cnt <= '0;
  end

  p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !cmd_busy) |=> (cmd_busy && !cmd_done));

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !cmd_busy);

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> (busy_cnt <= 32'(DEPTH)));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !start_wr) |=> cmd_done);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_overflow |=> tbl_overflow);

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_port)));
endmodule

bind mtbl_top mtbl_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .cmd_busy(cmd_busy), .cmd_done(cmd_done), .tbl_overflow(tbl_overflow),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
);

// File: tb/mtbl_top_test.sv
module mtbl_top_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cmd_busy, cmd_done, tbl_overflow;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [47:0] lk_mac = '0;
  logic [11:0] lk_vid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_port;

  always #2 clk = ~clk;

  mtbl_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done), .tbl_overflow(tbl_overflow),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_mac(lk_mac), .lk_vid(lk_vid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  bit [1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic launch(logic [47:0] mac, logic [11:0] vid, logic port, logic [2:0] age);
    wr(2'd0, {16'hbeef, mac[15:0]});   // upper half of the low register is junk (R1)
    wr(2'd1, mac[47:16]);
    wr(2'd2, {15'd0, vid, age, port, 1'b1});
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!cmd_done && n < DEPTH + 10) begin
      @(negedge clk);
      n++;
    end
    chk(tag, "done seen", cmd_done, 1);
    chk("R3", "cycles to done bounded", (n <= DEPTH + 2), 1);
    chk("R3", "busy low with done", cmd_busy, 0);
  endtask

  task automatic command(logic [47:0] mac, logic [11:0] vid, logic port, logic [2:0] age,
                         string tag);
    launch(mac, vid, port, age);
    wait_done(tag);
  endtask

  // driver: queue the expected answer when the query is accepted
  task automatic query(logic [47:0] mac, logic [11:0] vid, logic hit, logic port, string tag);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_mac = mac; lk_vid = vid;
    do @(negedge clk); while (!lk_ready);
    exp_q.push_back({hit, hit ? port : 1'b0});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  // monitor: compare each consumed response against the queue
  always @(negedge clk) begin : mon
    bit [1:0] e;
    string    t;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk("R9", "unexpected response", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "lookup hit", rsp_hit, e[1]);
        chk(t, "lookup port", rsp_port, e[0]);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired: actual running expected finished");
      summary();
    end
  end

  localparam logic [47:0] MAC_A = 48'h665544332211;
  localparam logic [47:0] MAC_B = 48'h0a0b0c0d0e0f;
  localparam logic [47:0] MAC_C = 48'h123456789abc;
  localparam logic [47:0] MAC_G = 48'h7777_0000_1111;

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "busy in reset", cmd_busy, 0);
    chk("R11", "done in reset", cmd_done, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "overflow after reset", tbl_overflow, 0);
    chk("R11", "rsp_valid after reset", rsp_valid, 0);
    query(48'h0, 12'h0, 0, 0, "R11");

    // install and address order
    command(MAC_A, 12'd5, 1'b0, 3'd1, "R4");
    query(MAC_A, 12'd5, 1, 0, "R4");
    query(MAC_A, 12'd6, 0, 0, "R9");
    query(48'h112233445566, 12'd5, 0, 0, "R1");
    chk("R4", "no overflow on install", tbl_overflow, 0);

    // refresh in place
    command(MAC_A, 12'd5, 1'b1, 3'd2, "R5");
    query(MAC_A, 12'd5, 1, 1, "R5");

    // removal, and removal of nothing
    command(MAC_A, 12'd5, 1'b0, 3'd0, "R6");
    query(MAC_A, 12'd5, 0, 0, "R6");
    command(MAC_C, 12'd9, 1'b0, 3'd0, "R6");
    chk("R6", "overflow untouched by empty removal", tbl_overflow, 0);

    // start bit clear and writes while busy
    @(negedge clk);
    chk("R2", "done before start", cmd_done, 1);
    wr(2'd2, {15'd0, 12'd3, 3'd1, 1'b0, 1'b0});
    @(negedge clk);
    chk("R8", "start clear keeps done", cmd_done, 1);
    chk("R8", "start clear not busy", cmd_busy, 0);
    launch(MAC_B, 12'd3, 1'b0, 3'd1);
    @(negedge clk);
    chk("R2", "busy after start", cmd_busy, 1);
    chk("R2", "done cleared", cmd_done, 0);
    wr(2'd0, {16'h0, MAC_C[15:0]});
    wr(2'd1, MAC_C[47:16]);
    wr(2'd2, {15'd0, 12'd3, 3'd1, 1'b1, 1'b1});
    wait_done("R8");
    query(MAC_B, 12'd3, 1, 0, "R8");
    query(MAC_C, 12'd3, 0, 0, "R8");

    // fill the table: B plus DEPTH-1 more
    for (int i = 0; i < DEPTH - 1; i++)
      command(48'h020000000000 + 48'(i), 12'd1, 1'b1, 3'd3, "R4");
    chk("R4", "full table no overflow yet", tbl_overflow, 0);
    command(MAC_B, 12'd3, 1'b1, 3'd1, "R5");
    chk("R5", "refresh on full table no overflow", tbl_overflow, 0);
    query(MAC_B, 12'd3, 1, 1, "R5");
    command(MAC_G, 12'd2, 1'b0, 3'd1, "R7");
    chk("R7", "overflow set", tbl_overflow, 1);
    query(MAC_G, 12'd2, 0, 0, "R7");
    query(48'h020000000007, 12'd1, 1, 1, "R7");
    command(48'h020000000000, 12'd1, 1'b0, 3'd0, "R6");
    chk("R7", "overflow sticky", tbl_overflow, 1);
    query(48'h020000000000, 12'd1, 0, 0, "R6");
    command(MAC_G, 12'd2, 1'b1, 3'd1, "R4");
    query(MAC_G, 12'd2, 1, 1, "R4");
    drain();

    // back-pressure on the response
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    query(MAC_B, 12'd3, 1, 1, "R10");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "rsp held valid", rsp_valid, 1);
      chk("R10", "lk_ready low", lk_ready, 0);
      chk("R10", "rsp hit held", rsp_hit, 1);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    drain();
    chk("R9", "all responses seen", exp_q.size(), 0);
    summary();
  end
endmodule